// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host three directly addressed registers (command, data and status) through which it reaches a much larger space of internal registers one access at a time. To read, the host writes a target register number into the command register and leaves the write flag clear. When the access finishes, the fetched word appears in the data register. To write, the host first places the value in the data register. It then writes the command register with the write flag set together with the target number.

On the far side the bridge drives a request/acknowledge back end whose latency is not fixed. Ordinary internal registers answer within a few cycles, while registers behind a slow serial management bus can take hundreds. The status register carries a ready flag, which stays low from the moment a command is accepted until the back end acknowledges, however long that takes. Only one access is ever in flight. A command that arrives while the bridge is busy is dropped and latches a sticky overrun flag.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the ready flag is 1, the overrun flag is 0, the data register reads 0 and `be_req` is low.
- R2: `host_sel` 0 selects the command register, 1 the data register and 2 the status register (bit 0 ready, bit 1 overrun); selector 3 reads as zero. Reading the command register returns the last accepted command, with the write flag in bit 15 and the register number in bits 9:0.
- R3: Writing the command register while idle with bit 15 clear starts a back-end read of the register numbered by bits 9:0. The acknowledged `be_rdata` is loaded into the data register.
- R4: Writing the command register while idle with bit 15 set starts a back-end write, to the numbered register, of the value held in the data register.
- R5: The ready flag is low from the cycle after an accepted command until the cycle after the acknowledge, for any back-end latency. With an acknowledge L cycles after the request is first seen, a host polling once per cycle sees ready low L+1 times.
- R6: At most one access is outstanding. `be_req` stays high with stable `be_addr`, `be_we` and `be_wdata` until `be_ack`, and it is low in the cycle after the acknowledge. Each accepted command produces exactly one back-end access.
- R7: A command-register write while busy is ignored: no new access starts, the command readback is unchanged, and the overrun flag is set. A data-register write while busy is also ignored.
- R8: The overrun flag is sticky. A status write with bit 1 clear leaves it set, and a status write with bit 1 set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 2 | Host register selector |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data of the selected register |
| be_req | output | 1 | Back-end access request |
| be_we | output | 1 | Back-end write (1) or read (0) |
| be_addr | output | ADDR_W | Back-end register number |
| be_wdata | output | DATA_W | Back-end write data |
| be_ack | input | 1 | Back-end completion |
| be_rdata | input | DATA_W | Back-end read data, valid with `be_ack` |

## Verification
The bench builds the bridge with its defaults: a 32-bit data word, a 10-bit register number, the write flag at bit 15 and the request held until acknowledge. Its back-end model answers registers 0 to 511 after 2 cycles and registers 512 to 1023 after 300 cycles. This reaches both short accesses and long ones, during which commands and data writes can collide with an access in flight. Random reads and writes over the whole 1024-entry space are mixed with directed overrun, sticky-flag and readback cases.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_DATA = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } ibr_sel_e;

   localparam int STAT_READY_BIT = 0;
   localparam int STAT_OVR_BIT   = 1;
endpackage

// File: rtl/ibr_host_regs.sv
module ibr_host_regs
   import ibr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 10,
   parameter int WE_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_sel,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              busy,
   input  logic              fill,
   input  logic [DATA_W-1:0] fill_data,
   output logic              start,
   output logic              start_we,
   output logic [ADDR_W-1:0] start_addr,
   output logic [DATA_W-1:0] data_q,
   output logic              ovr_q
);
   localparam logic [DATA_W-1:0] CMD_MASK =
      (DATA_W'(1) << WE_BIT) | ((DATA_W'(1) << ADDR_W) - DATA_W'(1));

   logic [DATA_W-1:0] cmd_q;
   logic              wr_cmd, wr_data, wr_stat;

   assign wr_cmd  = host_wr && (ibr_sel_e'(host_sel) == SEL_CMD);
   assign wr_data = host_wr && (ibr_sel_e'(host_sel) == SEL_DATA);
   assign wr_stat = host_wr && (ibr_sel_e'(host_sel) == SEL_STAT);

   assign start      = wr_cmd && !busy;
   assign start_we   = host_wdata[WE_BIT];
   assign start_addr = host_wdata[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (start) begin
         cmd_q <= host_wdata & CMD_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (fill) begin
         data_q <= fill_data;
      end else if (wr_data && !busy) begin
         data_q <= host_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
      end else if (wr_cmd && busy) begin
         ovr_q <= 1'b1;
      end else if (wr_stat && host_wdata[STAT_OVR_BIT]) begin
         ovr_q <= 1'b0;
      end
   end

   always_comb begin
      host_rdata = '0;
      unique case (ibr_sel_e'(host_sel))
         SEL_CMD:  host_rdata = cmd_q;
         SEL_DATA: host_rdata = data_q;
         SEL_STAT: begin
            host_rdata[STAT_READY_BIT] = !busy;
            host_rdata[STAT_OVR_BIT]   = ovr_q;
         end
         default:  host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 10,
   parameter bit HOLD_REQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_we,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] start_wdata,
   input  logic              be_ack,
   output logic              busy,
   output logic              fill,
   output logic              be_req,
   output logic              be_we,
   output logic [ADDR_W-1:0] be_addr,
   output logic [DATA_W-1:0] be_wdata
);
   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         be_we    <= 1'b0;
         be_addr  <= '0;
         be_wdata <= '0;
      end else if (start) begin
         busy_q   <= 1'b1;
         be_we    <= start_we;
         be_addr  <= start_addr;
         be_wdata <= start_wdata;
      end else if (busy_q && be_ack) begin
         busy_q   <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign fill = busy_q && be_ack && !be_we;

   generate
      if (HOLD_REQ) begin : g_level_req
         assign be_req = busy_q;
      end else begin : g_pulse_req
         logic sent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sent_q <= 1'b0;
            end else if (start) begin
               sent_q <= 1'b0;
            end else if (be_req) begin
               sent_q <= 1'b1;
            end
         end
         assign be_req = busy_q && !sent_q;
      end
   endgenerate
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 10,
   parameter int WE_BIT   = 15,
   parameter bit HOLD_REQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_sel,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              be_req,
   output logic              be_we,
   output logic [ADDR_W-1:0] be_addr,
   output logic [DATA_W-1:0] be_wdata,
   input  logic              be_ack,
   input  logic [DATA_W-1:0] be_rdata
);
   generate
      if (WE_BIT < ADDR_W || WE_BIT >= DATA_W) begin : g_bad_we_bit
         $error("write flag position must lie above the register number and inside the word");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("data word must hold the two status bits");
      end
   endgenerate

   logic              busy;
   logic              fill;
   logic              start;
   logic              start_we;
   logic [ADDR_W-1:0] start_addr;
   logic [DATA_W-1:0] data_q;
   logic              ovr;

   ibr_host_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .WE_BIT (WE_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_sel   (host_sel),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .busy       (busy),
      .fill       (fill),
      .fill_data  (be_rdata),
      .start      (start),
      .start_we   (start_we),
      .start_addr (start_addr),
      .data_q     (data_q),
      .ovr_q      (ovr)
   );

   ibr_seq #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .HOLD_REQ (HOLD_REQ)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_we    (start_we),
      .start_addr  (start_addr),
      .start_wdata (data_q),
      .be_ack      (be_ack),
      .busy        (busy),
      .fill        (fill),
      .be_req      (be_req),
      .be_we       (be_we),
      .be_addr     (be_addr),
      .be_wdata    (be_wdata)
   );
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 10,
   parameter bit HOLD_REQ = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [1:0]        host_sel,
   input logic              busy,
   input logic              ovr,
   input logic [DATA_W-1:0] data_q,
   input logic              be_req,
   input logic              be_ack,
   input logic              be_we,
   input logic [ADDR_W-1:0] be_addr,
   input logic [DATA_W-1:0] be_wdata
);
   p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == 2'd0 && !busy) |=> (busy && be_req));

   p_ready_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !be_ack) |=> busy);

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (HOLD_REQ && be_req && !be_ack) |=>
         (be_req && $stable(be_addr) && $stable(be_we) && $stable(be_wdata)));

   p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && be_ack) |=> !be_req);

   p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == 2'd0 && busy) |=> ovr);

   p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !be_ack) |=> $stable(data_q));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !(host_wr && host_sel == 2'd2)) |=> ovr);
endmodule

bind ind_reg_bridge ibr_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .HOLD_REQ (HOLD_REQ)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_wr  (host_wr),
   .host_sel (host_sel),
   .busy     (busy),
   .ovr      (ovr),
   .data_q   (data_q),
   .be_req   (be_req),
   .be_ack   (be_ack),
   .be_we    (be_we),
   .be_addr  (be_addr),
   .be_wdata (be_wdata)
);

// File: tb/ind_reg_bridge_tb.sv
module ind_reg_bridge_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 10;
   localparam int NREG = 1 << AW;
   localparam int LAT_FAST = 2;
   localparam int LAT_SLOW = 300;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    host_sel = 2'd0;
   logic          host_wr = 1'b0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          be_req, be_we;
   logic [AW-1:0] be_addr;
   logic [DW-1:0] be_wdata;
   logic          be_ack = 1'b0;
   logic [DW-1:0] be_rdata = '0;

   logic [DW-1:0] model_mem [NREG];
   logic [DW-1:0] exp_mem [NREG];
   int vectors = 0;
   int miscompares = 0;
   int n_access = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ind_reg_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .be_req(be_req),
      .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata),
      .be_ack(be_ack), .be_rdata(be_rdata)
   );

   function automatic logic [DW-1:0] seed_val(input int a);
      return 32'hC3A50000 ^ (a * 32'h0001_9E37);
   endfunction

   function automatic int lat_of(input int a);
      return (a >= NREG/2) ? LAT_SLOW : LAT_FAST;
   endfunction

   // back end: ack comes L negedges after the request is first seen
   initial begin
      bit act = 1'b0;
      int cnt = 0;
      for (int i = 0; i < NREG; i++) model_mem[i] = seed_val(i);
      forever begin
         @(negedge clk);
         if (be_ack) begin
            be_ack = 1'b0;
         end else if (be_req && !act) begin
            act = 1'b1;
            cnt = lat_of(int'(be_addr));
            n_access++;
         end else if (act) begin
            cnt--;
            if (cnt == 0) begin
               act = 1'b0;
               be_ack = 1'b1;
               if (be_we) model_mem[be_addr] = be_wdata;
               else       be_rdata = model_mem[be_addr];
            end
         end
      end
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [DW-1:0] val);
      @(negedge clk);
      host_sel = sel; host_wdata = val; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] sel, output logic [DW-1:0] val);
      host_sel = sel;
      #1;
      val = host_rdata;
   endtask

   // counts negedge polls with ready low, starting right after the command write
   task automatic wait_ready(output int lows);
      logic [DW-1:0] s;
      lows = 0;
      rd_reg(2'd2, s);
      while (!s[0] && lows < 1000) begin
         lows++;
         @(negedge clk);
         rd_reg(2'd2, s);
      end
   endtask

   task automatic do_read(input int a, input string tag);
      int lows;
      logic [DW-1:0] v;
      wr_reg(2'd0, DW'(a));
      wait_ready(lows);
      chk({tag, " R5 ready-low polls"}, DW'(lows), DW'(lat_of(a) + 1));
      rd_reg(2'd1, v);
      chk({tag, " R3 read data"}, v, exp_mem[a]);
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] val, input string tag);
      int lows;
      wr_reg(2'd1, val);
      wr_reg(2'd0, (DW'(1) << 15) | DW'(a));
      wait_ready(lows);
      chk({tag, " R5 ready-low polls"}, DW'(lows), DW'(lat_of(a) + 1));
      exp_mem[a] = val;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      int acc0, lows;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < NREG; i++) exp_mem[i] = seed_val(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(2'd2, v); chk("R1 status", v, 32'h1);
      rd_reg(2'd1, v); chk("R1 data", v, 32'h0);
      chk("R1 be_req", DW'(be_req), 32'h0);

      // R3/R4 directed, both latency classes
      do_read(5, "fast");
      rd_reg(2'd0, v); chk("R2 cmd readback", v, 32'h5);
      rd_reg(2'd3, v); chk("R2 unused selector", v, 32'h0);
      do_read(700, "slow");
      do_write(10, 32'h1234_5678, "fast wr R4");
      rd_reg(2'd0, v); chk("R2 cmd readback write flag", v, 32'h0000_800A);
      do_read(10, "fast rb R4");
      do_write(900, 32'hCAFE_F00D, "slow wr R4");
      do_read(900, "slow rb R4");

      // R7 collision with a slow read in flight
      acc0 = n_access;
      wr_reg(2'd0, DW'(600));
      wr_reg(2'd0, DW'(3));
      wr_reg(2'd1, 32'hDEAD_BEEF);
      rd_reg(2'd2, v); chk("R7 overrun set, still busy", v, 32'h2);
      rd_reg(2'd0, v); chk("R7 cmd readback unchanged", v, 32'd600);
      wait_ready(lows);
      rd_reg(2'd1, v); chk("R7 data holds first read result", v, exp_mem[600]);
      chk("R6 one access per command", DW'(n_access - acc0), 32'h1);

      // R7 data write while busy on a slow write
      do_write(520, 32'h0BAD_0001, "pre R7");
      wr_reg(2'd1, 32'h7777_0000);
      wr_reg(2'd0, (DW'(1) << 15) | DW'(530));
      wr_reg(2'd1, 32'h5555_AAAA);
      wait_ready(lows);
      exp_mem[530] = 32'h7777_0000;
      do_read(530, "R7 data write ignored");

      // R8 sticky overrun
      wr_reg(2'd2, 32'h1);
      rd_reg(2'd2, v); chk("R8 kept by write of bit1=0", v, 32'h3);
      wr_reg(2'd2, 32'h2);
      rd_reg(2'd2, v); chk("R8 cleared by write of bit1=1", v, 32'h1);

      // constrained random mix
      for (int n = 0; n < 50; n++) begin
         int a;
         bit w;
         a = int'($urandom % NREG);
         w = 1'($urandom % 2);
         if (w) do_write(a, $urandom, "rnd R4");
         else   do_read(a, "rnd R3");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule